// File: doc/BRIEF.md
# Serviced Watchdog Timer

A system watchdog for a chip's control fabric. Once software enables it, a down-counter counts from a programmed reload value, optionally slowed by a fixed clock prescaler. Software must keep it from expiring by writing a fixed pair of 16-bit key values to the service register, in order. If the count runs out, the block either pulses a system reset request or raises a level interrupt, as the configuration selects.

Software can write the configuration only once after power-on. The first write decides the reload value, the expiry action, the prescaler use and the debug-freeze behaviour, and usually whether the watchdog runs at all. A build variant starts the watchdog already running, and software cannot turn it off. An expiry in reset mode sets a sticky status flag. This flag survives everything except power-on reset, so boot code can tell that the watchdog caused the last restart.

Access uses a plain register port: write strobe, byte address, write data and a combinational read. The block decodes byte offset 0x0 (status), 0x4 (configuration), 0x8 (live count) and 0xE (service).

Top module: `wdog_svc`

## Requirements
- R1: After power-on reset, the configuration at offset 0x4 reads 0xFFFF0003 (reload 0xFFFF in bits 31:16, freeze bit 3 = 0, enable bit 2 = 0, expiry action bit 1 = 1 meaning reset, prescale bit 0 = 1), with bit 2 = 1 in the pre-enabled variant. The count at offset 0x8 reads 0xFFFF in bits 16:0. After the first configuration write, offset 0x4 reads back the written fields.
- R2: Once enabled, the first expiry happens exactly T clocks after the edge that accepted the configuration write, where T = reload × (PRESCALE if bit 0 is set, else 1). A reload of 0 counts as 65536. The count is never 0 and never above 65536.
- R3: A write of 0x556C to offset 0xE, followed by a write of 0xAA39 as the next service write, reloads the counter and clears the prescaler on the edge that accepts 0xAA39. The next expiry is then T clocks later.
- R4: Any other service write clears the pending first key without reloading. A repeated 0x556C keeps the key pending. Writes to other offsets between the two keys leave the pending key untouched.
- R5: Only the first configuration write after power-on takes effect. Later writes change neither the fields nor the running count.
- R6: With HW_ON=1, the enable bit is 1 from power-on and stays 1 whatever software writes.
- R7: In reset mode, an expiry drives rstReq high for the one clock after the expiring edge, and irqOut stays low.
- R8: In interrupt mode, an expiry sets irqOut. It stays high while the counter keeps reloading and running, and only a completed service pair clears it.
- R9: A reset-mode expiry sets the status flag in bit 0 of offset 0x0. Writing 1 to that bit clears it. Writing 0 leaves it set.
- R10: While freezeIn is high and the freeze bit is set, the counter and prescaler hold. With the freeze bit clear, freezeIn has no effect.
- R11: While disabled, the counter holds its loaded value and never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Byte offset of the access |
| regWdata | input | 32 | Write data (service key in bits 15:0) |
| regRdata | output | 32 | Combinational read data for regAddr |
| freezeIn | input | 1 | Debug halt request |
| rstReq | output | 1 | One-clock system reset request |
| irqOut | output | 1 | Level expiry interrupt |

## Verification
Configuration and service writes take effect on the edge that accepts them, so the count read at the following falling edge already holds the reloaded value. Each idle clock after that lowers it by one, or by one every PRESCALE clocks when the prescaler is on. rstReq and irqOut are registered, so they appear in the clock after the expiring edge. The bench counts falling edges from the accepting write and expects the output after exactly reload × prescale of them. Each sampled value is compared against an offset computed from the number of writes and idle clocks since the last reload.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [3:0]  ADR_STAT = 4'h0;
  localparam logic [3:0]  ADR_CTRL = 4'h4;
  localparam logic [3:0]  ADR_CNT  = 4'h8;
  localparam logic [3:0]  ADR_SVC  = 4'hE;
  localparam logic [15:0] KEY_ARM  = 16'h556C;
  localparam logic [15:0] KEY_FIRE = 16'hAA39;
  localparam int CNT_W = 17;

  typedef struct packed {
    logic [15:0] tc;
    logic        frz;
    logic        en;
    logic        rstSel;
    logic        ps;
  } wdCfg_t;

  typedef struct packed {
    logic svcDone;
    logic cfgLoad;
  } wdStrb_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter bit HW_ON = 1'b0
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               regWe,
  input  logic [3:0]         regAddr,
  input  logic [31:0]        regWdata,
  input  logic               expireNow,
  input  logic [CNT_W-1:0]   cnt,
  output wdCfg_t             cfg,
  output wdStrb_t            strb,
  output logic [CNT_W-1:0]   loadVal,
  output logic               rstReq,
  output logic               irqOut,
  output logic               rstFlag,
  output logic [31:0]        regRdata
);
  logic locked;
  logic armed;
  logic cfgWr;
  logic svcWr;
  logic statWr;
  logic [15:0] tcSel;

  assign cfgWr  = regWe && (regAddr == ADR_CTRL) && !locked;
  assign svcWr  = regWe && (regAddr == ADR_SVC);
  assign statWr = regWe && (regAddr == ADR_STAT);

  assign strb.cfgLoad = cfgWr;
  assign strb.svcDone = svcWr && armed && (regWdata[15:0] == KEY_FIRE);

  assign tcSel   = cfgWr ? regWdata[31:16] : cfg.tc;
  assign loadVal = (tcSel == 16'h0) ? CNT_W'(17'h10000) : {1'b0, tcSel};

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cfg     <= '{tc: 16'hFFFF, frz: 1'b0, en: HW_ON, rstSel: 1'b1, ps: 1'b1};
      locked  <= 1'b0;
      armed   <= 1'b0;
      rstReq  <= 1'b0;
      irqOut  <= 1'b0;
      rstFlag <= 1'b0;
    end else begin
      if (cfgWr) begin
        cfg.tc     <= regWdata[31:16];
        cfg.frz    <= regWdata[3];
        cfg.en     <= HW_ON ? 1'b1 : regWdata[2];
        cfg.rstSel <= regWdata[1];
        cfg.ps     <= regWdata[0];
        locked     <= 1'b1;
      end
      if (svcWr) armed <= (regWdata[15:0] == KEY_ARM);
      rstReq <= expireNow && cfg.rstSel;
      if (strb.svcDone)                    irqOut <= 1'b0;
      else if (expireNow && !cfg.rstSel)   irqOut <= 1'b1;
      if (expireNow && cfg.rstSel)         rstFlag <= 1'b1;
      else if (statWr && regWdata[0])      rstFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADR_STAT: regRdata = {31'b0, rstFlag};
      ADR_CTRL: regRdata = {cfg.tc, 12'b0, cfg.frz, cfg.en, cfg.rstSel, cfg.ps};
      ADR_CNT:  regRdata = {{(32-CNT_W){1'b0}}, cnt};
      default:  regRdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 65536
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             freezeIn,
  input  wdCfg_t           cfg,
  input  wdStrb_t          strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             expireNow
);
  logic load;
  logic run;
  logic preWrap;
  logic tick;

  assign load = strb.svcDone | strb.cfgLoad;
  assign run  = cfg.en && !(freezeIn && cfg.frz);

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;
      assign preWrap = (pre == PW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge porN) begin
        if (!porN)                pre <= '0;
        else if (load)            pre <= '0;
        else if (run && cfg.ps)   pre <= preWrap ? '0 : pre + 1'b1;
      end
    end else begin : g_nopre
      assign preWrap = 1'b1;
    end
  endgenerate

  assign tick      = run && (!cfg.ps || preWrap);
  assign expireNow = tick && (cnt == CNT_W'(1)) && !load;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)      cnt <= CNT_W'(17'h0FFFF);
    else if (load)  cnt <= loadVal;
    else if (tick)  cnt <= (cnt == CNT_W'(1)) ? loadVal : cnt - 1'b1;
  end
endmodule

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
#(
  parameter int PRESCALE = 65536,
  parameter bit HW_ON    = 1'b0
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        regWe,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        freezeIn,
  output logic        rstReq,
  output logic        irqOut
);
  wdCfg_t           cfg;
  wdStrb_t          strb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cnt;
  logic             expireNow;
  logic             rstFlag;

  wdog_ctrl #(.HW_ON(HW_ON)) u_ctrl (
    .clk(clk), .porN(porN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .expireNow(expireNow), .cnt(cnt), .cfg(cfg),
    .strb(strb), .loadVal(loadVal), .rstReq(rstReq), .irqOut(irqOut),
    .rstFlag(rstFlag), .regRdata(regRdata)
  );

  wdog_dp #(.PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .porN(porN), .freezeIn(freezeIn), .cfg(cfg), .strb(strb),
    .loadVal(loadVal), .cnt(cnt), .expireNow(expireNow)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter bit HW_ON = 1'b0
) (
  input logic        clk,
  input logic        porN,
  input logic        regWe,
  input logic [3:0]  regAddr,
  input logic        freezeIn,
  input logic [19:0] cfgWord,
  input logic [16:0] cnt,
  input logic        svcDone,
  input logic        loadAny,
  input logic        rstReq,
  input logic        irqOut,
  input logic        rstFlag
);
  logic seenWr;
  logic cfgEn;
  logic frzBit;

  assign cfgEn  = cfgWord[2];
  assign frzBit = cfgWord[3];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) seenWr <= 1'b0;
    else if (regWe && regAddr == 4'h4) seenWr <= 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!porN)
    (cnt != 17'd0) && (cnt <= 17'h10000));
  p_cfg_lock_r5: assert property (@(posedge clk) disable iff (!porN)
    seenWr |=> $stable(cfgWord));
  p_hw_on_r6: assert property (@(posedge clk) disable iff (!porN)
    (HW_ON != 1'b0) |-> cfgEn);
  p_excl_r7: assert property (@(posedge clk) disable iff (!porN)
    !(rstReq && $rose(irqOut)));
  p_irq_clr_r8: assert property (@(posedge clk) disable iff (!porN)
    $fell(irqOut) |-> $past(svcDone));
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!porN)
    rstReq |-> rstFlag);
  p_freeze_r10: assert property (@(posedge clk) disable iff (!porN)
    (freezeIn && frzBit && !loadAny) |=> $stable(cnt));
  p_idle_r11: assert property (@(posedge clk) disable iff (!porN)
    !cfgEn |=> !rstReq);
endmodule

bind wdog_svc wdog_chk #(.HW_ON(HW_ON)) u_chk (
  .clk(clk), .porN(porN), .regWe(regWe), .regAddr(regAddr),
  .freezeIn(freezeIn), .cfgWord(cfg), .cnt(cnt), .svcDone(strb.svcDone),
  .loadAny(strb.svcDone | strb.cfgLoad), .rstReq(rstReq), .irqOut(irqOut),
  .rstFlag(rstFlag)
);

// File: tb/sim_wdog_svc.sv
module sim_wdog_svc;
  localparam int P = 4;
  logic clk = 1'b0;
  logic porN = 1'b0;
  logic regWe = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [31:0] regWdata = 32'h0;
  logic freezeIn = 1'b0;
  logic [31:0] rd0, rd1;
  logic rstReq0, irq0, rstReq1, irq1;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdog_svc #(.PRESCALE(P), .HW_ON(1'b0)) u0 (
    .clk(clk), .porN(porN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(rd0), .freezeIn(freezeIn),
    .rstReq(rstReq0), .irqOut(irq0));

  wdog_svc #(.PRESCALE(P), .HW_ON(1'b1)) u1 (
    .clk(clk), .porN(porN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(rd1), .freezeIn(freezeIn),
    .rstReq(rstReq1), .irqOut(irq1));

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [15:0] tc, input logic f,
                                     input logic e, input logic r, input logic p);
    return {tc, 12'b0, f, e, r, p};
  endfunction

  task automatic doReset();
    @(negedge clk);
    regWe = 1'b0; freezeIn = 1'b0; porN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v0, output logic [31:0] v1);
    regAddr = a;
    #1;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic waitSig(input bit useIrq, input int limit, output int n);
    n = 0;
    while (!(useIrq ? irq0 : rstReq0) && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    int n;
    bit sawRst;

    // Reset state: R1, R6
    doReset();
    rd(4'h4, a, b);
    chk("R1 ctrl reset", a, 32'hFFFF0003);
    chk("R6 ctrl reset preenabled", b, 32'hFFFF0007);
    rd(4'h8, a, b);
    chk("R1 count reset", a, 32'h0000FFFF);
    chk("R1 rstReq idle", rstReq0, 0);
    chk("R1 irq idle", irq0, 0);

    // Timeout sweep: R2, R7, R9, R1 readback
    for (int ps = 0; ps < 2; ps++) begin
      for (int tc = 1; tc <= 5; tc++) begin
        int per;
        per = tc * (ps != 0 ? P : 1);
        doReset();
        wr(4'h4, mk(16'(tc), 1'b0, 1'b1, 1'b1, 1'(ps)));
        rd(4'h4, a, b);
        chk("R1 readback", a, mk(16'(tc), 1'b0, 1'b1, 1'b1, 1'(ps)));
        waitSig(1'b0, 100, n);
        chk("R2 timeout", n, per);
        chk("R7 irq low in reset mode", irq0, 0);
        rd(4'h0, a, b);
        chk("R9 flag set", a[0], 1);
        if (per > 1) begin
          @(negedge clk);
          chk("R7 pulse one clock", rstReq0, 0);
        end
      end
    end

    // Zero reload means 65536; W1C status: R2, R9
    doReset();
    wr(4'h4, mk(16'h0, 1'b0, 1'b1, 1'b1, 1'b0));
    rd(4'h8, a, b);
    chk("R2 zero reload count", a, 32'h10000);
    waitSig(1'b0, 70000, n);
    chk("R2 zero reload timeout", n, 65536);
    wr(4'h0, 32'h0);
    rd(4'h0, a, b);
    chk("R9 write 0 keeps flag", a[0], 1);
    wr(4'h0, 32'h1);
    rd(4'h0, a, b);
    chk("R9 write 1 clears flag", a[0], 0);

    // Interrupt mode: R8, R3
    doReset();
    wr(4'h4, mk(16'd6, 1'b0, 1'b1, 1'b0, 1'b0));
    waitSig(1'b1, 100, n);
    chk("R8 irq timeout", n, 6);
    chk("R8 no reset request", rstReq0, 0);
    repeat (10) @(negedge clk);
    chk("R8 irq held", irq0, 1);
    rd(4'h0, a, b);
    chk("R8 no status flag", a[0], 0);
    wr(4'hE, 32'h556C);
    chk("R8 irq held after first key", irq0, 1);
    wr(4'hE, 32'hAA39);
    chk("R8 irq cleared by service", irq0, 0);
    rd(4'h8, a, b);
    chk("R3 reload on service", a, 6);

    // Sequence detector: R3, R4
    doReset();
    wr(4'h4, mk(16'd50, 1'b0, 1'b1, 1'b1, 1'b0));
    wr(4'hE, 32'h556C); wr(4'hE, 32'h1234); wr(4'hE, 32'hAA39);
    rd(4'h8, a, b);
    chk("R4 broken pair no reload", a, 47);
    wr(4'hE, 32'h556C); wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
    rd(4'h8, a, b);
    chk("R4 repeated first key", a, 50);
    wr(4'hE, 32'hAA39);
    rd(4'h8, a, b);
    chk("R4 lone second key", a, 49);
    wr(4'hE, 32'h556C); wr(4'h0, 32'h0); wr(4'hE, 32'hAA39);
    rd(4'h8, a, b);
    chk("R4 other offset keeps key", a, 50);
    repeat (10) @(negedge clk);
    wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
    waitSig(1'b0, 100, n);
    chk("R3 full timeout after service", n, 50);

    // Prescaler cleared by service: R3
    doReset();
    wr(4'h4, mk(16'd3, 1'b0, 1'b1, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    wr(4'hE, 32'h556C); wr(4'hE, 32'hAA39);
    waitSig(1'b0, 100, n);
    chk("R3 prescaled timeout after service", n, 3 * P);

    // Write-once: R5, R6, R11
    doReset();
    wr(4'h4, mk(16'd8, 1'b0, 1'b1, 1'b1, 1'b0));
    wr(4'h4, mk(16'd3, 1'b0, 1'b0, 1'b0, 1'b0));
    rd(4'h4, a, b);
    chk("R5 second write ignored", a, mk(16'd8, 1'b0, 1'b1, 1'b1, 1'b0));
    waitSig(1'b0, 100, n);
    chk("R5 running count untouched", n, 7);
    doReset();
    wr(4'h4, mk(16'd4, 1'b0, 1'b0, 1'b1, 1'b0));
    rd(4'h4, a, b);
    chk("R6 enable forced on", b, mk(16'd4, 1'b0, 1'b1, 1'b1, 1'b0));
    wr(4'h4, mk(16'd4, 1'b0, 1'b1, 1'b1, 1'b0));
    rd(4'h4, a, b);
    chk("R5 late enable ignored", a[2], 0);
    sawRst = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rstReq0 || irq0) sawRst = 1;
    end
    chk("R11 disabled never expires", sawRst, 0);
    rd(4'h8, a, b);
    chk("R11 disabled count holds", a, 4);

    // Freeze: R10
    doReset();
    wr(4'h4, mk(16'd30, 1'b1, 1'b1, 1'b1, 1'b0));
    freezeIn = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'h8, a, b);
    chk("R10 frozen count", a, 30);
    freezeIn = 1'b0;
    @(negedge clk);
    rd(4'h8, a, b);
    chk("R10 resumes", a, 29);
    doReset();
    wr(4'h4, mk(16'd30, 1'b0, 1'b1, 1'b1, 1'b0));
    freezeIn = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'h8, a, b);
    chk("R10 freeze bit clear ignores input", a, 25);
    freezeIn = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule